// File: doc/BRIEF.md
# Asynchronous SRAM controller with byte lanes

This block connects a simple on-chip request port to an external asynchronous static RAM of 65,536 words by 16 bits that shares one bidirectional data bus for reads and writes. A host offers one request at a time: an address, write data, a write flag and two byte strobes, qualified by a valid/ready handshake. Read results come back on a separate data output marked by a one-cycle valid pulse.

Each access is split into phases whose lengths are whole clock cycles. Each length is derived from the clock period and from the memory's nanosecond minimums through parameters, rounded up, and is never shorter than one cycle. A write keeps output enable high for its whole duration, so the shorter write-pulse minimum applies. It then waits a turnaround gap so that any data the memory was still driving from an earlier read has floated. Only then does it lower write enable and drive the bus, and it lets go of the bus on the same edge that ends the pulse. A read holds chip select and output enable low for the access-time count. It captures the bus on the edge that ends that count. Any byte lane that was not requested is returned as zero.

Top module: `asramCtrl`

## Requirements
- R1: In reset and right after it, chip select, write enable, output enable and both byte controls are high (inactive), the request port shows ready high, and read-valid is low.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready stays low for as long as chip select is low, and it returns high only after the access has finished.
- R3: During an access, the lower byte control (for bus bits 7:0) is low exactly when request strobe bit 0 is 1. The upper byte control (for bus bits 15:8) is low exactly when strobe bit 1 is 1. A write changes only the memory lanes whose control is low.
- R4: During a write, output enable stays high and chip select stays low for the whole time write enable is low. Write enable falls only after chip select has been low for at least the turnaround count. It stays low for at least the pulse count. With the defaults (8 ns clock, 5 ns float, 7 ns pulse, 5 ns data setup), the turnaround count is 1 cycle and the pulse count is 1 cycle.
- R5: While write enable is low, the controller drives the request's full 16-bit write data onto the bus.
- R6: The memory address output equals the request address and stays unchanged for as long as chip select is low.
- R7: A read holds write enable high and chip select and output enable low for at least the access count (2 cycles with the 10 ns default access time). It then gives one read-valid pulse carrying the memory word, with bits of unrequested lanes forced to zero. Every read returns exactly one result, in request order.
- R8: Whenever ready is high, the memory is deselected, with all five control lines high.
- R9: The controller never drives the bus (write enable low) while the memory is still driving it, either during a read or within the float time after the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWData | input | 16 | Write data |
| reqBe | input | 2 | Byte strobes: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspValid | output | 1 | One-cycle read-result pulse |
| rspData | output | 16 | Read result, unrequested lanes zero |
| sramCsN | output | 1 | Memory chip select, active low |
| sramWeN | output | 1 | Memory write enable, active low |
| sramOeN | output | 1 | Memory output enable, active low |
| sramLbN | output | 1 | Lower byte control, active low |
| sramUbN | output | 1 | Upper byte control, active low |
| sramAddr | output | 16 | Memory address |
| sramDq | inout | 16 | Shared memory data bus |

## Verification
Directed sequences come first: full-word writes and reads, then lower-only and upper-only writes into a word that already holds data, then single-lane reads of that word. Together these separate correct lane gating and zero masking from whole-word behaviour. A write issued right after a read stresses the float-time turnaround: the bench memory model keeps driving its outputs after the read ends, so a missing gap appears as contention. A long random mix of reads and writes with random lanes over a small address window is then compared against a reference array. In that mix, the model returns garbage until the access count has elapsed, so an early capture shows up as a data mismatch.

// File: rtl/asramPkg.sv
package asramPkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // take a new request
    logic drvOn;    // start driving the bus (write pulse begins)
    logic done;     // access ends, release lanes and bus
    logic capture;  // sample read data
  } asramStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_GAP   = 2'd1,
    S_PULSE = 2'd2,
    S_READ  = 2'd3
  } asramPhase_t;

  // nanoseconds to whole clock cycles, rounded up, at least one
  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asramSeq.sv
module asramSeq
  import asramPkg::*;
#(
  parameter int CLK_NS  = 8,
  parameter int T_WP_NS = 7,
  parameter int T_DW_NS = 5,
  parameter int T_AA_NS = 10,
  parameter int T_HZ_NS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output logic         csN,
  output logic         weN,
  output logic         oeN,
  output asramStrobe_t stb
);

  localparam int WP_CYC  = maxOf(nsToCyc(T_WP_NS, CLK_NS), nsToCyc(T_DW_NS, CLK_NS));
  localparam int AA_CYC  = nsToCyc(T_AA_NS, CLK_NS);
  localparam int HZ_CYC  = nsToCyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = maxOf(maxOf(WP_CYC, AA_CYC), HZ_CYC);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  asramPhase_t stQ, stNext;
  logic [CNT_W-1:0] cntQ, cntNext;
  logic cntZero;

  assign cntZero = (cntQ == '0);

  always_comb begin
    stNext  = stQ;
    cntNext = cntQ;
    stb     = '0;
    unique case (stQ)
      S_IDLE: begin
        if (reqValid) begin
          stb.load = 1'b1;
          if (reqWrite) begin
            stNext  = S_GAP;
            cntNext = CNT_W'(HZ_CYC - 1);
          end else begin
            stNext  = S_READ;
            cntNext = CNT_W'(AA_CYC - 1);
          end
        end
      end
      S_GAP: begin
        if (cntZero) begin
          stNext    = S_PULSE;
          cntNext   = CNT_W'(WP_CYC - 1);
          stb.drvOn = 1'b1;
        end else begin
          cntNext = cntQ - CNT_W'(1);
        end
      end
      S_PULSE: begin
        if (cntZero) begin
          stNext   = S_IDLE;
          stb.done = 1'b1;
        end else begin
          cntNext = cntQ - CNT_W'(1);
        end
      end
      S_READ: begin
        if (cntZero) begin
          stNext      = S_IDLE;
          stb.done    = 1'b1;
          stb.capture = 1'b1;
        end else begin
          cntNext = cntQ - CNT_W'(1);
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ      <= S_IDLE;
      cntQ     <= '0;
      reqReady <= 1'b1;
      csN      <= 1'b1;
      weN      <= 1'b1;
      oeN      <= 1'b1;
    end else begin
      stQ      <= stNext;
      cntQ     <= cntNext;
      reqReady <= (stNext == S_IDLE);
      csN      <= (stNext == S_IDLE);
      weN      <= (stNext != S_PULSE);
      oeN      <= (stNext != S_READ);
    end
  end

endmodule

// File: rtl/asramPath.sv
module asramPath
  import asramPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  asramStrobe_t      stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W/8-1:0] laneN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] capWord;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign capWord[l*8 +: 8] = laneN[l] ? 8'h00 : dqIn[l*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sramAddr <= '0;
      dqOut    <= '0;
      laneN    <= '1;
    end else if (stb.load) begin
      sramAddr <= reqAddr;
      dqOut    <= reqWData;
      laneN    <= ~reqBe;
    end else if (stb.done) begin
      laneN    <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dqOe <= 1'b0;
    end else if (stb.drvOn) begin
      dqOe <= 1'b1;
    end else if (stb.done) begin
      dqOe <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= stb.capture;
      if (stb.capture) rspData <= capWord;
    end
  end

endmodule

// File: rtl/asramCtrl.sv
module asramCtrl
  import asramPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 8,
  parameter int T_WP_NS = 7,
  parameter int T_DW_NS = 5,
  parameter int T_AA_NS = 10,
  parameter int T_HZ_NS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [1:0]        reqBe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramLbN,
  output logic              sramUbN,
  output logic [ADDR_W-1:0] sramAddr,
  inout  wire  [DATA_W-1:0] sramDq
);

  asramStrobe_t      stb;
  logic [1:0]        laneN;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  asramSeq #(
    .CLK_NS (CLK_NS),
    .T_WP_NS(T_WP_NS),
    .T_DW_NS(T_DW_NS),
    .T_AA_NS(T_AA_NS),
    .T_HZ_NS(T_HZ_NS)
  ) uSeq (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .csN     (sramCsN),
    .weN     (sramWeN),
    .oeN     (sramOeN),
    .stb     (stb)
  );

  asramPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWData(reqWData),
    .reqBe   (reqBe),
    .dqIn    (sramDq),
    .sramAddr(sramAddr),
    .laneN   (laneN),
    .dqOut   (dqOut),
    .dqOe    (dqOe),
    .rspData (rspData),
    .rspValid(rspValid)
  );

  assign sramLbN = laneN[0];
  assign sramUbN = laneN[1];
  assign sramDq  = dqOe ? dqOut : {DATA_W{1'bz}};

endmodule

// File: rtl/asramCheck.sv
module asramCheck #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rspValid,
  input logic              sramCsN,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramLbN,
  input logic              sramUbN,
  input logic [ADDR_W-1:0] sramAddr
);

  a_r8_idle_deselected: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (sramCsN && sramWeN && sramOeN && sramLbN && sramUbN));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !sramCsN |-> !reqReady);

  a_r4_write_oe_high: assert property (@(posedge clk) disable iff (rst)
    !sramWeN |-> (sramOeN && !sramCsN));

  a_r3_write_has_lane: assert property (@(posedge clk) disable iff (rst)
    !sramWeN |-> (!sramLbN || !sramUbN));

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!sramCsN && $past(!sramCsN)) |-> $stable(sramAddr));

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  a_r9_no_read_in_write: assert property (@(posedge clk) disable iff (rst)
    !sramOeN |-> sramWeN);

endmodule

bind asramCtrl asramCheck #(.ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rst     (rst),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .sramCsN (sramCsN),
  .sramWeN (sramWeN),
  .sramOeN (sramOeN),
  .sramLbN (sramLbN),
  .sramUbN (sramUbN),
  .sramAddr(sramAddr)
);

// File: tb/sim_asramCtrl.sv
`timescale 1ns/1ps
module sim_asramCtrl;

  localparam int HZ_CYC = 1;
  localparam int WP_CYC = 1;
  localparam int AA_CYC = 2;
  localparam int DEPTH  = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr  = '0;
  logic [15:0] reqWData = '0;
  logic [1:0]  reqBe    = '0;
  logic        reqReady, rspValid;
  logic [15:0] rspData, sramAddr;
  logic        sramCsN, sramWeN, sramOeN, sramLbN, sramUbN;
  wire  [15:0] sramDq;

  asramCtrl u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData), .sramCsN(sramCsN), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramLbN(sramLbN), .sramUbN(sramUbN), .sramAddr(sramAddr),
    .sramDq(sramDq)
  );

  int errors = 0;
  int checks = 0;

  logic [15:0] mem [DEPTH];
  logic [15:0] refMem [DEPTH];
  logic [15:0] expQ [$];

  logic [15:0] curAddr = '0;
  logic [15:0] curWData = '0;
  logic [1:0]  curBe = '0;

  // behavioural memory drive
  logic        memLoOn = 1'b0, memHiOn = 1'b0;
  logic [15:0] memVal = '0;
  assign sramDq[7:0]  = memLoOn ? memVal[7:0]  : 8'bz;
  assign sramDq[15:8] = memHiOn ? memVal[15:8] : 8'bz;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor and memory model, sampled mid-cycle
  logic        prevWe = 1'b1, prevRead = 1'b0, prevValid = 1'b0, readMode;
  logic        lastLb = 1'b1, lastUb = 1'b1;
  logic [15:0] lastDq = '0, expW;
  logic [7:0]  lastA = '0;
  int weCnt = 0, csCnt = 0, readCyc = 0, lastReadLen = 0, tail = 0, cycles = 0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rst) begin
      readMode = !sramCsN && !sramOeN && sramWeN;
      if (reqReady)
        check(sramCsN && sramWeN && sramOeN && sramLbN && sramUbN, "R8 idle lines",
              {27'd0, sramCsN, sramWeN, sramOeN, sramLbN, sramUbN}, 32'h1f);
      if (!sramCsN) begin
        csCnt++;
        check(sramLbN == !curBe[0] && sramUbN == !curBe[1], "R3 lane controls",
              {30'd0, sramUbN, sramLbN}, {30'd0, !curBe[1], !curBe[0]});
        check(sramAddr == curAddr, "R6 address", sramAddr, curAddr);
        check(!reqReady, "R2 ready while busy", reqReady, 0);
      end else begin
        csCnt = 0;
      end
      // write side
      if (!sramWeN) begin
        weCnt++;
        if (prevWe) check(csCnt - 1 >= HZ_CYC, "R4 turnaround", csCnt - 1, HZ_CYC);
        check(sramOeN && !sramCsN, "R4 oe/cs in write", {30'd0, sramOeN, sramCsN}, 32'h2);
        check(sramDq == curWData, "R5 bus data", sramDq, curWData);
        check(!(memLoOn || memHiOn), "R9 contention", {30'd0, memHiOn, memLoOn}, 0);
        lastDq = sramDq; lastLb = sramLbN; lastUb = sramUbN; lastA = sramAddr[7:0];
      end else if (!prevWe) begin
        check(weCnt >= WP_CYC, "R4 pulse length", weCnt, WP_CYC);
        if (!lastLb) mem[lastA][7:0]  = lastDq[7:0];
        if (!lastUb) mem[lastA][15:8] = lastDq[15:8];
        weCnt = 0;
      end
      // read side
      if (readMode) readCyc++;
      else if (prevRead) begin lastReadLen = readCyc; readCyc = 0; end
      if (rspValid) begin
        check(!prevValid, "R7 single pulse", prevValid, 0);
        check(lastReadLen >= AA_CYC, "R7 access length", lastReadLen, AA_CYC);
        if (expQ.size() == 0) check(0, "R7 unexpected result", rspData, 0);
        else begin
          expW = expQ.pop_front();
          check(rspData == expW, "R7 read data", rspData, expW);
        end
      end
      // memory output drive with float tail
      if (readMode) begin
        tail = HZ_CYC;
        memLoOn = !sramLbN;
        memHiOn = !sramUbN;
        memVal = (readCyc >= AA_CYC) ? mem[sramAddr[7:0]] : 16'h5AA5;
      end else if (tail > 0) begin
        tail--;
      end else begin
        memLoOn = 1'b0;
        memHiOn = 1'b0;
      end
      prevWe = sramWeN;
      prevRead = readMode;
      prevValid = rspValid;
    end
  end

  task automatic doReq(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] m;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWData = d; reqBe = be;
    curAddr = a; curWData = d; curBe = be;
    m = {{8{be[1]}}, {8{be[0]}}};
    if (wr) refMem[a[7:0]] = (refMem[a[7:0]] & ~m) | (d & m);
    else    expQ.push_back(refMem[a[7:0]] & m);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 16'(i * 16'h0107);
      refMem[i] = 16'(i * 16'h0107);
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(sramCsN && sramWeN && sramOeN && sramLbN && sramUbN, "R1 reset lines",
          {27'd0, sramCsN, sramWeN, sramOeN, sramLbN, sramUbN}, 32'h1f);
    check(reqReady, "R1 ready in reset", reqReady, 1);
    check(!rspValid, "R1 no result in reset", rspValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(reqReady && sramCsN, "R1 idle after reset", {30'd0, reqReady, sramCsN}, 32'h3);

    // directed lane tests
    doReq(1, 16'd5, 16'h1234, 2'b11);
    doReq(0, 16'd5, 16'h0000, 2'b11);
    doReq(1, 16'd5, 16'hABCD, 2'b01);
    doReq(0, 16'd5, 16'h0000, 2'b11);
    doReq(1, 16'd5, 16'h77EE, 2'b10);
    doReq(0, 16'd5, 16'h0000, 2'b01);
    doReq(0, 16'd5, 16'h0000, 2'b10);
    // write right after read to exercise turnaround
    doReq(0, 16'd9, 16'h0000, 2'b11);
    doReq(1, 16'd9, 16'hC0DE, 2'b11);
    doReq(0, 16'd9, 16'h0000, 2'b11);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] be;
      be = 2'($urandom_range(1, 3));
      doReq(1'($urandom_range(0, 1)), 16'($urandom_range(0, DEPTH - 1)), 16'($urandom), be);
    end

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R7 all reads returned", expQ.size(), 0);
    check(reqReady, "R2 idle at end", reqReady, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule